// File: doc/BRIEF.md
# Flash Write-Completion Poll Sequencer

After a write transfer to a serial flash device has finished, this block waits for the device to report that the write is complete. It repeatedly reads the device status register. Each read is one chip-select transaction: one command byte goes out and one status byte comes back. The block tests one chosen bit of each returned byte against a chosen level. Completion is declared after a programmed number of back-to-back passing reads. Between reads, chip select stays inactive for a programmable gap.

The surrounding controller pulses `start_i` after each device write and leaves the configuration inputs stable in that cycle. The block samples the configuration at that moment. It then drives an abstract byte-level handshake: a command byte with valid/ready, and a response byte qualified by a valid strobe. The physical shifter that serves this handshake sits outside the block.

Automatic polling can be switched off, in which case completion is reported at once. An optional expiry limits the number of reads. When the limit is reached without completion, the block reports a timeout in place of completion.

Top module: `flash_wr_poll_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o`, `cs_o` and `cmd_valid_o` are all 0.
- R2: Each poll asserts `cs_o` together with `cmd_valid_o`. `cmd_byte_o` holds the sampled opcode and stays stable until `cmd_ready_i`. After that, `cmd_valid_o` drops while `cs_o` stays high until a cycle with `rsp_valid_i`. In the next cycle `cs_o` is low.
- R3: A read passes when bit `bit_sel_i` (0 = LSB, 7 = MSB) of `rsp_byte_i` equals `polarity_i` (1: passes on a 1; 0: passes on a 0).
- R4: `done_o` pulses once the number of consecutive passing reads reaches `need_cnt_i`. A failing read clears the run. A value of 0 behaves as 1.
- R5: Between two polls, `cs_o` is low for exactly `gap_i + 1` cycles.
- R6: If `poll_off_i` is 1 at start, `done_o` pulses in the following cycle and no poll is made.
- R7: With `expiry_en_i` = 1, `timeout_o` pulses if the poll that brings the total to `max_polls_i` does not complete; a limit of 0 behaves as 1. If that same poll completes, `done_o` pulses instead. With `expiry_en_i` = 0, polling continues until completion.
- R8: `done_o` and `timeout_o` are one-cycle pulses and never high together. Each appears in the cycle after the deciding response or start, and `busy_o` is already 0 in that cycle.
- R9: A `start_i` pulse while `busy_o` is 1 has no effect.
- R10: The configuration is sampled at an accepted start. Input changes while busy do not change the opcode, the bit, the polarity, the count, the gap or the limit in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Write finished; begin polling |
| poll_off_i | input | 1 | Skip polling; report done at once |
| expiry_en_i | input | 1 | Enable the poll limit |
| opcode_i | input | DATA_W (8) | Status-read command byte |
| bit_sel_i | input | IDX_W (3) | Index of the tested status bit |
| polarity_i | input | 1 | Level that counts as complete |
| need_cnt_i | input | CNT_W (8) | Consecutive passing reads required |
| gap_i | input | GAP_W (8) | Extra chip-select-inactive cycles between polls |
| max_polls_i | input | LIMIT_W (16) | Poll limit when expiry is enabled |
| cmd_valid_o | output | 1 | Command byte valid |
| cmd_byte_o | output | DATA_W (8) | Command byte |
| cmd_ready_i | input | 1 | Command byte accepted |
| rsp_valid_i | input | 1 | Status byte valid |
| rsp_byte_i | input | DATA_W (8) | Returned status byte |
| cs_o | output | 1 | Chip select, active high |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Expiry pulse |

## Verification
The hardest situation to reach is a run of passing reads that is broken just short of the required count. The block must then need a full fresh run, while the gap timer and the poll limit keep counting across the break. The bench feeds scripted status sequences with failing reads placed at fixed positions and sweeps the required count over them. It also sweeps every bit index and polarity, using bytes in which only the tested bit differs. Start pulses and scrambled configuration are injected inside a gap. The limit sweep includes the case where completion lands on exactly the last allowed poll.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } poll_state_e;
endpackage

// File: rtl/fwp_bit_test.sv
module fwp_bit_test #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              pol_i,
  output logic              hit_o
);
  logic sel_bit;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (idx_i == IDX_W'(i)) sel_bit = data_i[i];
    end
  end

  assign hit_o = (sel_bit == pol_i);
endmodule

// File: rtl/fwp_streak_ctr.sv
module fwp_streak_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             reached_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   need_eff;

  assign cnt_inc   = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign need_eff  = (need_i == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, need_i};
  assign reached_o = upd_i && hit_i && (cnt_inc >= need_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (upd_i) begin
      if (!hit_i)         cnt_q <= '0;
      else if (!cnt_inc[CNT_W]) cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/fwp_poll_limiter.sv
module fwp_poll_limiter #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               upd_i,
  input  logic               en_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               expire_o
);
  logic [LIMIT_W-1:0] cnt_q;
  logic [LIMIT_W:0]   cnt_inc;
  logic [LIMIT_W:0]   limit_eff;

  assign cnt_inc   = {1'b0, cnt_q} + {{LIMIT_W{1'b0}}, 1'b1};
  assign limit_eff = (limit_i == '0) ? {{LIMIT_W{1'b0}}, 1'b1} : {1'b0, limit_i};
  assign expire_o  = upd_i && en_i && (cnt_inc >= limit_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (upd_i && !cnt_inc[LIMIT_W]) begin
      cnt_q <= cnt_inc[LIMIT_W-1:0];
    end
  end
endmodule

// File: rtl/fwp_gap_timer.sv
module fwp_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] val_i,
  input  logic             run_i,
  output logic             zero_o
);
  logic [GAP_W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (run_i && !zero_o) begin
      cnt_q <= cnt_q - GAP_W'(1);
    end
  end
endmodule

// File: rtl/flash_wr_poll_seq.sv
module flash_wr_poll_seq
  import fwp_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          CNT_W      = 8,
  parameter int          GAP_W      = 8,
  parameter int          LIMIT_W    = 16,
  parameter logic [7:0]  RST_OPCODE = 8'h05,
  localparam int         IDX_W      = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               poll_off_i,
  input  logic               expiry_en_i,
  input  logic [DATA_W-1:0]  opcode_i,
  input  logic [IDX_W-1:0]   bit_sel_i,
  input  logic               polarity_i,
  input  logic [CNT_W-1:0]   need_cnt_i,
  input  logic [GAP_W-1:0]   gap_i,
  input  logic [LIMIT_W-1:0] max_polls_i,
  output logic               cmd_valid_o,
  output logic [DATA_W-1:0]  cmd_byte_o,
  input  logic               cmd_ready_i,
  input  logic               rsp_valid_i,
  input  logic [DATA_W-1:0]  rsp_byte_i,
  output logic               cs_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o
);
  poll_state_e        state_q, state_d;
  logic [DATA_W-1:0]  opcode_q;
  logic [IDX_W-1:0]   idx_q;
  logic               pol_q;
  logic [CNT_W-1:0]   need_q;
  logic [GAP_W-1:0]   gap_q;
  logic               exp_en_q;
  logic [LIMIT_W-1:0] max_q;
  logic               done_q, tmo_q;

  logic start_ok, rsp_fire, hit, reached, expire, gap_zero;

  assign start_ok = start_i && (state_q == ST_IDLE);
  assign rsp_fire = (state_q == ST_WAIT) && rsp_valid_i;

  // configuration is frozen for the whole poll sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opcode_q <= DATA_W'(RST_OPCODE);
      idx_q    <= '0;
      pol_q    <= 1'b0;
      need_q   <= CNT_W'(1);
      gap_q    <= '0;
      exp_en_q <= 1'b0;
      max_q    <= '0;
    end else if (start_ok) begin
      opcode_q <= opcode_i;
      idx_q    <= bit_sel_i;
      pol_q    <= polarity_i;
      need_q   <= need_cnt_i;
      gap_q    <= gap_i;
      exp_en_q <= expiry_en_i;
      max_q    <= max_polls_i;
    end
  end

  fwp_bit_test #(.DATA_W(DATA_W)) u_bit_test (
    .data_i (rsp_byte_i),
    .idx_i  (idx_q),
    .pol_i  (pol_q),
    .hit_o  (hit)
  );

  fwp_streak_ctr #(.CNT_W(CNT_W)) u_streak (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .upd_i     (rsp_fire),
    .hit_i     (hit),
    .need_i    (need_q),
    .reached_o (reached)
  );

  fwp_poll_limiter #(.LIMIT_W(LIMIT_W)) u_limiter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok),
    .upd_i    (rsp_fire),
    .en_i     (exp_en_q),
    .limit_i  (max_q),
    .expire_o (expire)
  );

  fwp_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rsp_fire),
    .val_i  (gap_q),
    .run_i  (state_q == ST_GAP),
    .zero_o (gap_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_ok && !poll_off_i) state_d = ST_SEND;
      ST_SEND: if (cmd_ready_i)             state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i)             state_d = (reached || expire) ? ST_IDLE : ST_GAP;
      ST_GAP:  if (gap_zero)                state_d = ST_SEND;
      default:                              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (start_ok && poll_off_i) || (rsp_fire && reached);
      tmo_q   <= rsp_fire && !reached && expire;
    end
  end

  assign cmd_valid_o = (state_q == ST_SEND);
  assign cmd_byte_o  = opcode_q;
  assign cs_o        = (state_q == ST_SEND) || (state_q == ST_WAIT);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              poll_off_i,
  input logic              cmd_valid_o,
  input logic [DATA_W-1:0] cmd_byte_o,
  input logic              cmd_ready_i,
  input logic              rsp_valid_i,
  input logic              cs_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              exp_en_q
);
  assert_cmd_in_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cs_o);

  assert_cmd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_byte_o)));

  assert_cs_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o && !cmd_valid_o && !rsp_valid_i) |=> cs_o);

  assert_done_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(rsp_valid_i) || $past(start_i)));

  assert_off_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && poll_off_i) |=> (done_o && !cs_o));

  assert_tmo_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> exp_en_q);

  assert_pulse_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_pulse_tmo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));

  assert_idle_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> !busy_o);
endmodule

bind flash_wr_poll_seq fwp_checker #(.DATA_W(DATA_W)) u_fwp_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .poll_off_i  (poll_off_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_byte_o  (cmd_byte_o),
  .cmd_ready_i (cmd_ready_i),
  .rsp_valid_i (rsp_valid_i),
  .cs_o        (cs_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .exp_en_q    (exp_en_q)
);

// File: tb/tb_flash_wr_poll_seq.sv
module tb_flash_wr_poll_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i = 0, poll_off_i = 0, expiry_en_i = 0, polarity_i = 0;
  logic [7:0]  opcode_i = 8'h05, need_cnt_i = 8'd1, gap_i = 8'd0;
  logic [2:0]  bit_sel_i = 3'd0;
  logic [15:0] max_polls_i = 16'd0;
  logic        cmd_ready_i = 0, rsp_valid_i = 0;
  logic [7:0]  rsp_byte_i = 8'h00;
  logic        cmd_valid_o, cs_o, busy_o, done_o, timeout_o;
  logic [7:0]  cmd_byte_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  flash_wr_poll_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .poll_off_i(poll_off_i),
    .expiry_en_i(expiry_en_i), .opcode_i(opcode_i), .bit_sel_i(bit_sel_i),
    .polarity_i(polarity_i), .need_cnt_i(need_cnt_i), .gap_i(gap_i),
    .max_polls_i(max_polls_i), .cmd_valid_o(cmd_valid_o), .cmd_byte_o(cmd_byte_o),
    .cmd_ready_i(cmd_ready_i), .rsp_valid_i(rsp_valid_i), .rsp_byte_i(rsp_byte_i),
    .cs_o(cs_o), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] seq [0:31];

  always @(posedge clk_i) cyc++;

  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [2:0] idx, input bit pol,
                     input logic [7:0] need, input logic [7:0] gap, input bit off,
                     input bit expn, input logic [15:0] maxp, input int nseq, input bit poke);
    int fin = -1, streak = 0, need_e, max_e;
    bit fin_done = 0;
    need_e = (need == 0) ? 1 : int'(need);
    max_e  = (maxp == 0) ? 1 : int'(maxp);
    for (int p = 0; p < nseq && fin < 0; p++) begin
      streak = (seq[p][idx] == pol) ? streak + 1 : 0;
      if (streak >= need_e)          begin fin = p; fin_done = 1; end
      else if (expn && p + 1 >= max_e) begin fin = p; fin_done = 0; end
    end
    @(negedge clk_i);
    opcode_i = op; bit_sel_i = idx; polarity_i = pol; need_cnt_i = need;
    gap_i = gap; poll_off_i = off; expiry_en_i = expn; max_polls_i = maxp;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    if (off) begin
      chk(done_o === 1'b1, "R6 done", int'(done_o), 1);
      chk(!busy_o && !cs_o && !timeout_o, "R6 no poll", int'(cs_o), 0);
      @(negedge clk_i);
      chk(!done_o && !cs_o, "R8 pulse", int'(done_o), 0);
      return;
    end
    if (fin < 0) begin
      chk(0, "bench script", fin, 0);
      return;
    end
    for (int p = 0; p <= fin; p++) begin
      int lo = 0, w = 0;
      while (!cmd_valid_o && w < 2000) begin
        if (!cs_o) lo++;
        if (poke && p == 1 && w == 0) begin
          start_i = 1; opcode_i = ~op; bit_sel_i = idx + 3'd1; polarity_i = ~pol;
          need_cnt_i = need + 8'd3; gap_i = gap + 8'd4; max_polls_i = maxp + 16'd7;
        end else start_i = 0;
        @(negedge clk_i);
        w++;
      end
      start_i = 0;
      if (p > 0) chk(lo == int'(gap) + 1, poke ? "R5/R10 gap" : "R5 gap", lo, int'(gap) + 1);
      chk(cs_o && cmd_byte_o == op, poke ? "R2/R10 opcode" : "R2 opcode", int'(cmd_byte_o), int'(op));
      cmd_ready_i = 1;
      @(negedge clk_i);
      cmd_ready_i = 0;
      chk(!cmd_valid_o && cs_o, "R2 wait cs", int'(cs_o), 1);
      @(negedge clk_i);
      chk(cs_o && busy_o, "R2 cs held", int'(cs_o), 1);
      rsp_valid_i = 1; rsp_byte_i = seq[p];
      @(negedge clk_i);
      rsp_valid_i = 0; rsp_byte_i = 8'h00;
      if (p == fin) begin
        chk(done_o == fin_done, fin_done ? "R4 done" : "R7 no done", int'(done_o), int'(fin_done));
        chk(timeout_o == !fin_done, "R7 timeout", int'(timeout_o), int'(!fin_done));
        chk(!busy_o && !cs_o, "R8 idle", int'(busy_o), 0);
        @(negedge clk_i);
        chk(!done_o && !timeout_o, "R8 pulse", int'(done_o | timeout_o), 0);
      end else begin
        chk(!done_o && !timeout_o && !cs_o && busy_o, poke ? "R3/R9 continue" : "R3 continue",
            int'({done_o, timeout_o, cs_o, busy_o}), 1);
      end
    end
  endtask

  initial begin
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !timeout_o && !cs_o && !cmd_valid_o, "R1 reset",
        int'({busy_o, done_o, timeout_o, cs_o, cmd_valid_o}), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !cs_o, "R1 idle", int'(busy_o), 0);

    // R3: every bit index and both polarities
    for (int i = 0; i < 8; i++) begin
      for (int pl = 0; pl < 2; pl++) begin
        logic [7:0] m;
        m = 8'(1 << i);
        seq[0] = pl ? ~m : m;
        seq[1] = pl ? m : ~m;
        run(8'h05 ^ 8'(i << 4), 3'(i), pl[0], 8'd1, 8'(i % 3), 0, 0, 16'd0, 2, pl == 1);
      end
    end

    // R4: broken runs against several required counts
    for (int n = 0; n < 6; n++) begin
      logic [7:0] need_v [0:5];
      need_v = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd7};
      for (int p = 0; p < 20; p++) seq[p] = (p == 1 || p == 4 || p == 6) ? 8'h00 : 8'h20;
      if (need_v[n] <= 1) seq[0] = 8'h00;
      run(8'hD7, 3'd5, 1'b1, need_v[n], 8'd1, 0, 0, 16'd0, 20, n == 3);
    end

    // R5: gap lengths
    for (int g = 0; g < 5; g++) begin
      logic [7:0] gap_v [0:4];
      gap_v = '{8'd0, 8'd1, 8'd2, 8'd5, 8'd200};
      for (int p = 0; p < 4; p++) seq[p] = 8'hFE;
      run(8'h9F, 3'd0, 1'b0, 8'd3, gap_v[g], 0, 0, 16'd0, 4, 0);
    end

    // R7: expiry limits with no completion
    for (int k = 0; k < 4; k++) begin
      logic [15:0] lim_v [0:3];
      lim_v = '{16'd0, 16'd1, 16'd2, 16'd4};
      for (int p = 0; p < 8; p++) seq[p] = 8'h01;
      run(8'h05, 3'd0, 1'b0, 8'd1, 8'd0, 0, 1, lim_v[k], 8, 0);
    end
    // R7: completion on the last allowed poll wins
    for (int p = 0; p < 4; p++) seq[p] = 8'h80;
    run(8'h05, 3'd7, 1'b1, 8'd3, 8'd2, 0, 1, 16'd3, 4, 0);
    // R7: no expiry keeps polling
    for (int p = 0; p < 13; p++) seq[p] = (p == 12) ? 8'h00 : 8'h01;
    run(8'h05, 3'd0, 1'b0, 8'd1, 8'd0, 0, 0, 16'd1, 13, 1);

    // R6: polling switched off
    run(8'h05, 3'd0, 1'b0, 8'd4, 8'd3, 1, 0, 16'd0, 0, 0);
    run(8'h70, 3'd6, 1'b1, 8'd2, 8'd0, 1, 1, 16'd1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule